// File: doc/BRIEF.md
# Four-Phase Register Bus Master

This block sits between a simple host request port and an on-chip register bus that uses a full four-phase handshake. The host presents a request strobe, a read flag, a byte address and write data. When the block is ready it launches one bus cycle. The select line stays high until the slave's acknowledge is seen. Select is then dropped, and the block waits for the acknowledge to fall before it will start another cycle. The host gets a one-clock completion pulse, with the read data and an error flag valid in that same clock.

Slave latency may be any length. An optional watchdog, set by parameters, ends a cycle whose acknowledge never arrives. It drops select and reports the completion with the error flag set. The ORed slave interrupt line is registered and passed to the host. The data word is 8, 16 or 32 bits wide. Host addresses are byte addresses, and the address bits below the word boundary are not driven onto the bus.

Top module: `regbus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, b_sel, h_done and h_err are 0 and h_ready is 1.
- R2: The bus cycle starts at a clock edge where h_req and h_ready are both 1. From the next cycle b_sel is 1, b_read equals h_rd, b_wdata equals h_wdata and b_addr equals h_addr[ADDR_W-1:LSB]. LSB is 0, 1 or 2 for a 8, 16 or 32-bit word. b_addr, b_read and b_wdata stay stable while b_sel is 1.
- R3: b_sel stays high until b_dtack is sampled high, or until the watchdog expires. It goes low on the following edge.
- R4: After b_sel falls, no new cycle starts while b_dtack is sampled high. h_ready is 0 from the accepting edge until b_dtack is seen low.
- R5: With a slave that acknowledges on the first edge after it sees select, and with a release that is just as prompt, consecutive rising edges of b_sel are exactly 4 clocks apart under a held request.
- R6: h_done is a one-clock pulse in the same cycle that b_sel first reads 0. h_rdata then holds the b_rdata sampled with the acknowledge for a read, and 0 for a write.
- R7: A request made while h_ready is 0 has no effect. The bus address, direction and write data of the running cycle do not change, and the slave's storage is not written.
- R8: With TIMEOUT_EN=1, if b_dtack has not been seen by the TIMEOUT_CYCLES-th edge after select rose, b_sel drops on that edge. h_done then arrives with h_err=1 and h_rdata=0. A cycle that is acknowledged reports h_err=0.
- R9: h_irq equals b_irq delayed by one clock.
- R10: If the slave acknowledges L edges later than the fastest case, h_done appears L+2 edges after the accepting edge, for any L below the watchdog limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host side and bus |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request strobe |
| h_rd | input | 1 | 1 = read, 0 = write |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | DATA_W | Host write data |
| h_ready | output | 1 | Block can accept a request this cycle |
| h_done | output | 1 | One-clock completion pulse |
| h_err | output | 1 | Completion was a watchdog abort |
| h_rdata | output | DATA_W | Read result, valid with h_done |
| h_irq | output | 1 | Registered bus interrupt |
| b_sel | output | 1 | Bus cycle select |
| b_read | output | 1 | Bus direction, 1 = read |
| b_addr | output | ADDR_W-LSB | Bus word address |
| b_wdata | output | DATA_W | Bus write data |
| b_dtack | input | 1 | ORed slave acknowledge |
| b_rdata | input | DATA_W | ORed slave read data |
| b_irq | input | 1 | ORed slave interrupt |

## Verification
A bench slave with adjustable acknowledge latency, adjustable release delay and a mute mode drives the bus. Writes followed by reads, using byte addresses with nonzero low bits, show whether the address bits are mapped correctly and whether data is captured or zeroed. Latencies of zero and several cycles separate a master that truly waits for the acknowledge from one that runs on fixed timing. A held request with a prompt and then a slow release shows whether the block waits for the acknowledge to fall. A request raised while busy shows whether held-off requests leak onto the bus. The mute slave checks the watchdog's abort point and its error report.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_REL  = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic fire;
        logic err;
        logic rd;
    } finish_t;

    function automatic int word_lsb(input int dw);
        if (dw == 32) return 2;
        if (dw == 16) return 1;
        return 0;
    endfunction

endpackage

// File: rtl/regbus_timer.sv
module regbus_timer #(
    parameter bit TIMEOUT_EN     = 1'b1,
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    generate
        if (TIMEOUT_EN) begin : g_on
            localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || !run) cnt_q <= '0;
                else             cnt_q <= cnt_q + 1'b1;
            end
            assign expired = run && (cnt_q == CW'(TIMEOUT_CYCLES - 1));
        end else begin : g_off
            logic unused_tmr;
            assign unused_tmr = clk ^ rst ^ run;
            assign expired    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/regbus_resp.sv
module regbus_resp
    import regbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  finish_t           fin,
    input  logic [DATA_W-1:0] b_rdata,
    output logic              h_done,
    output logic              h_err,
    output logic [DATA_W-1:0] h_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            h_done  <= 1'b0;
            h_err   <= 1'b0;
            h_rdata <= '0;
        end else begin
            h_done <= fin.fire;
            if (fin.fire) begin
                h_err   <= fin.err;
                h_rdata <= (fin.rd && !fin.err) ? b_rdata : '0;
            end
        end
    end
endmodule

// File: rtl/regbus_master.sv
module regbus_master
    import regbus_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int ADDR_W         = 8,
    parameter bit TIMEOUT_EN     = 1'b1,
    parameter int TIMEOUT_CYCLES = 16,
    localparam int LSB           = word_lsb(DATA_W),
    localparam int BA_W          = ADDR_W - LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic              h_done,
    output logic              h_err,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    output logic              b_sel,
    output logic              b_read,
    output logic [BA_W-1:0]   b_addr,
    output logic [DATA_W-1:0] b_wdata,
    input  logic              b_dtack,
    input  logic [DATA_W-1:0] b_rdata,
    input  logic              b_irq
);
    bus_state_e state_q;
    logic       accept;
    logic       expired;
    finish_t    fin;

    generate
        if (LSB > 0) begin : g_lo
            logic unused_lo;
            assign unused_lo = ^h_addr[LSB-1:0];
        end
    endgenerate

    // Released state counts as idle once the acknowledge is seen low.
    assign h_ready = (state_q == ST_IDLE) || (state_q == ST_REL && !b_dtack);
    assign accept  = h_ready && h_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            b_sel   <= 1'b0;
            b_read  <= 1'b0;
            b_addr  <= '0;
            b_wdata <= '0;
        end else if (accept) begin
            state_q <= ST_ACK;
            b_sel   <= 1'b1;
            b_read  <= h_rd;
            b_addr  <= h_addr[ADDR_W-1:LSB];
            b_wdata <= h_wdata;
        end else begin
            unique case (state_q)
                ST_ACK: if (b_dtack || expired) begin
                    state_q <= ST_REL;
                    b_sel   <= 1'b0;
                end
                ST_REL: if (!b_dtack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fin.fire = (state_q == ST_ACK) && (b_dtack || expired);
    assign fin.err  = !b_dtack;
    assign fin.rd   = b_read;

    regbus_timer #(
        .TIMEOUT_EN    (TIMEOUT_EN),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == ST_ACK),
        .expired(expired)
    );

    regbus_resp #(.DATA_W(DATA_W)) u_resp (
        .clk    (clk),
        .rst    (rst),
        .fin    (fin),
        .b_rdata(b_rdata),
        .h_done (h_done),
        .h_err  (h_err),
        .h_rdata(h_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) h_irq <= 1'b0;
        else     h_irq <= b_irq;
    end
endmodule

// File: rtl/regbus_master_chk.sv
module regbus_master_chk #(
    parameter int DATA_W         = 32,
    parameter int BA_W           = 6,
    parameter bit TIMEOUT_EN     = 1'b1,
    parameter int TIMEOUT_CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              h_ready,
    input logic              h_done,
    input logic              h_err,
    input logic              h_irq,
    input logic              b_sel,
    input logic              b_read,
    input logic [BA_W-1:0]   b_addr,
    input logic [DATA_W-1:0] b_wdata,
    input logic              b_dtack,
    input logic              b_irq
);
    int wait_cnt;
    always_ff @(posedge clk) begin
        if (rst || !b_sel || b_dtack) wait_cnt <= 0;
        else                          wait_cnt <= wait_cnt + 1;
    end

    a_r2_stable_bus: assert property (@(posedge clk) disable iff (rst)
        (b_sel && $past(b_sel)) |-> ($stable(b_addr) && $stable(b_read) && $stable(b_wdata)));

    a_r3_hold_sel: assert property (@(posedge clk) disable iff (rst)
        (b_sel && !b_dtack) |=> (b_sel || (h_done && h_err)));

    a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        (b_sel && b_dtack) |=> !b_sel);

    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        (!b_sel && b_dtack) |=> !b_sel);

    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        b_sel |-> !h_ready);

    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(b_sel) |-> h_done);

    a_r6_done_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        h_done |-> (!b_sel && $past(b_sel)));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        h_done |=> !h_done);

    a_r9_irq_follow: assert property (@(posedge clk) disable iff (rst)
        h_irq == $past(b_irq));

    generate
        if (TIMEOUT_EN) begin : g_to
            a_r8_wait_bound: assert property (@(posedge clk) disable iff (rst)
                wait_cnt <= TIMEOUT_CYCLES);
        end
    endgenerate
endmodule

bind regbus_master regbus_master_chk #(
    .DATA_W        (DATA_W),
    .BA_W          (BA_W),
    .TIMEOUT_EN    (TIMEOUT_EN),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .h_ready(h_ready),
    .h_done (h_done),
    .h_err  (h_err),
    .h_irq  (h_irq),
    .b_sel  (b_sel),
    .b_read (b_read),
    .b_addr (b_addr),
    .b_wdata(b_wdata),
    .b_dtack(b_dtack),
    .b_irq  (b_irq)
);

// File: tb/tb_regbus_master.sv
`timescale 1ns/1ps
module tb_regbus_master;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int TO = 16;
    localparam int BW = AW - 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          h_req = 1'b0, h_rd = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0;
    logic          h_ready, h_done, h_err, h_irq;
    logic [DW-1:0] h_rdata;
    logic          b_sel, b_read;
    logic [BW-1:0] b_addr;
    logic [DW-1:0] b_wdata;
    logic          b_dtack = 1'b0;
    logic [DW-1:0] b_rdata = '0;
    logic          b_irq = 1'b0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // slave model controls
    int lat = 0;
    int rel = 0;
    bit mute = 0;
    int lat_cnt = 0;
    int rel_cnt = 0;
    logic [DW-1:0] mem [64];

    always #2 clk = ~clk;

    regbus_master #(
        .DATA_W(DW), .ADDR_W(AW), .TIMEOUT_EN(1'b1), .TIMEOUT_CYCLES(TO)
    ) dut (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_done(h_done), .h_err(h_err), .h_rdata(h_rdata),
        .h_irq(h_irq),
        .b_sel(b_sel), .b_read(b_read), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_dtack(b_dtack), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            b_dtack <= 1'b0; b_rdata <= '0; lat_cnt <= 0; rel_cnt <= 0;
        end else if (b_sel && !b_dtack && !mute) begin
            rel_cnt <= 0;
            if (lat_cnt >= lat) begin
                b_dtack <= 1'b1;
                if (b_read) b_rdata <= mem[b_addr];
                else        mem[b_addr] <= b_wdata;
            end else lat_cnt <= lat_cnt + 1;
        end else if (!b_sel) begin
            lat_cnt <= 0;
            if (b_dtack) begin
                if (rel_cnt >= rel) begin
                    b_dtack <= 1'b0; b_rdata <= '0; rel_cnt <= 0;
                end else rel_cnt <= rel_cnt + 1;
            end
        end
    end

    // rising-edge log of b_sel, sampled on the falling clock edge
    logic sel_prev = 1'b0;
    int   rise_last = 0;
    int   rise_gap = 0;
    always @(negedge clk) begin
        if (b_sel && !sel_prev) begin
            rise_gap  <= cyc - rise_last;
            rise_last <= cyc;
        end
        sel_prev <= b_sel;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic txn(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       output logic [DW-1:0] rdat, output logic er, output int n);
        bit stable_ok = 1;
        @(negedge clk);
        while (!h_ready) @(negedge clk);
        h_req = 1'b1; h_rd = rd; h_addr = a; h_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        h_req = 1'b0;
        n = 0;
        while (!h_done && n < 1000) begin
            if (b_sel && (b_addr != a[AW-1:2] || b_read != rd || (!rd && b_wdata != wd)))
                stable_ok = 0;
            @(negedge clk);
            n++;
        end
        rdat = h_rdata; er = h_err;
        check(stable_ok, "R2 bus fields", {1'b0, b_addr}, {1'b0, a[AW-1:2]});
        check(!b_sel, "R6 sel low with done", b_sel, 0);
    endtask

    task automatic t_reset();
        check(b_sel == 0 && h_done == 0 && h_err == 0, "R1 outputs in reset",
              {b_sel, h_done, h_err}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(h_ready == 1 && b_sel == 0, "R1 ready after reset", {h_ready, b_sel}, 2'b10);
    endtask

    task automatic t_write_read();
        logic [DW-1:0] r; logic e; int n;
        lat = 0; rel = 0;
        txn(1'b0, 8'h13, 32'hA5A5_1234, r, e, n);
        check(r == 0, "R6 write returns zero data", r, 0);
        check(e == 0, "R8 no error on ack", e, 0);
        check(mem[4] == 32'hA5A5_1234, "R2 byte 0x13 lands in word 4", mem[4], 32'hA5A5_1234);
        txn(1'b1, 8'h10, '0, r, e, n);
        check(r == 32'hA5A5_1234, "R6 read data captured", r, 32'hA5A5_1234);
        check(n == 2, "R10 fast slave done after 2 edges", n, 2);
    endtask

    task automatic t_latency();
        logic [DW-1:0] r; logic e; int n;
        mem[9] = 32'h0BAD_F00D;
        lat = 3;
        txn(1'b1, 8'h24, '0, r, e, n);
        check(n == 5, "R10 latency 3 gives done at 5", n, 5);
        check(r == 32'h0BAD_F00D, "R3 read after slow ack", r, 32'h0BAD_F00D);
        lat = 7;
        txn(1'b0, 8'h24, 32'h7777_0001, r, e, n);
        check(n == 9 && e == 0, "R10 latency 7 gives done at 9", n, 9);
        lat = 0;
    endtask

    task automatic t_back2back(input int d);
        int dones = 0;
        rel = d;
        @(negedge clk);
        while (!h_ready) @(negedge clk);
        h_req = 1'b1; h_rd = 1'b1; h_addr = 8'h04;
        while (dones < 2) begin
            @(negedge clk);
            if (h_done) dones++;
        end
        h_req = 1'b0;
        if (d == 0) check(rise_gap == 4, "R5 four-clock spacing", rise_gap, 4);
        else        check(rise_gap == 4 + d, "R4 waits for dtack release", rise_gap, 4 + d);
        rel = 0;
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] r; logic e; int n;
        bit ok = 1;
        mem[12] = 32'h1111_2222;
        lat = 4;
        @(negedge clk);
        while (!h_ready) @(negedge clk);
        h_req = 1'b1; h_rd = 1'b1; h_addr = 8'h10;
        @(posedge clk);
        @(negedge clk);
        h_rd = 1'b0; h_addr = 8'h30; h_wdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (b_addr != 6'd4 || b_read != 1'b1 || h_ready) ok = 0;
        end
        h_req = 1'b0;
        check(ok, "R7 busy request leaves bus alone", {1'b0, b_addr}, 4);
        lat = 0;
        txn(1'b1, 8'h30, '0, r, e, n);
        check(r == 32'h1111_2222, "R7 held-off write not performed", r, 32'h1111_2222);
    endtask

    task automatic t_timeout();
        logic [DW-1:0] r; logic e; int n;
        mute = 1;
        txn(1'b1, 8'h04, '0, r, e, n);
        check(e == 1, "R8 timeout error flag", e, 1);
        check(n == TO, "R8 abort edge", n, TO);
        check(r == 0, "R8 timeout data zero", r, 0);
        mute = 0;
        txn(1'b1, 8'h04, '0, r, e, n);
        check(e == 0, "R8 recovery after abort", e, 0);
    endtask

    task automatic t_irq();
        @(negedge clk); b_irq = 1'b1;
        check(h_irq == 0, "R9 irq not yet passed", h_irq, 0);
        @(negedge clk);
        check(h_irq == 1, "R9 irq passed after one clock", h_irq, 1);
        b_irq = 1'b0;
        @(negedge clk);
        check(h_irq == 0, "R9 irq clears", h_irq, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_latency();
        t_back2back(0);
        t_back2back(3);
        t_busy_ignore();
        t_timeout();
        t_irq();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule